// File: doc/BRIEF.md
# Low Pin Count I/O Target

This block sits on the peripheral side of a Low Pin Count bus and answers host I/O cycles aimed at a fixed window of the 16-bit I/O space. It watches the active-low frame strobe and the four bidirectional data lines (split here into an input nibble, an output nibble and an output enable). When a cycle is an I/O read or I/O write and its address falls inside the window, it claims the bus. It inserts a fixed number of short-wait SYNC nibbles, then a ready SYNC, moves the data byte if there is one, and hands the bus back with a turnaround.

Each bus cycle moves exactly one byte between the bus and a plain internal register port. The port has an address, write data, a one-cycle write strobe, read data and a one-cycle read strobe. Other cycle types, addresses outside the window and cycles cut short by the frame strobe leave the lines undriven and the register port untouched. The window base, the window size and the number of wait SYNCs are module parameters.

Top module: `lpc_io_target`

## Requirements
- R1: While reset is held low, and in the cycle after it is released, the LAD output enable is 0 and neither register strobe is asserted.
- R2: A cycle starts when the frame strobe is low and LAD is 0000. If the frame strobe stays low for several clocks, the last such clock is the START. A clock with the frame strobe low and LAD not 0000 starts nothing.
- R3: The nibble after START selects the cycle: 0000 is an I/O read and 0010 is an I/O write. Every other value is ignored until the next frame strobe. LAD is never driven for it and no strobe fires.
- R4: The four address nibbles arrive most significant first. The target claims the cycle only when BASE_ADDR <= address < BASE_ADDR + WINDOW_SIZE. On a miss it drives nothing and fires no strobe.
- R5: For a write, the data byte arrives low nibble first, followed by two host turnaround clocks. On a hit, regWr pulses for one clock during the second host turnaround clock, carrying the full address and byte. A frame strobe before that clock suppresses the pulse.
- R6: For a read hit, regRd pulses for one clock during the second host turnaround clock. The byte returned on regRdata in that clock is driven after the ready SYNC, low nibble first.
- R7: On a hit the target drives exactly WAIT_SYNCS (at least 1) nibbles of 0101, then one nibble of 0000.
- R8: After the ready SYNC (write) or the high data nibble (read), the target drives 1111 for one clock and then releases LAD.
- R9: When the frame strobe is sampled low, the output enable is 0 on the next clock and decoding restarts.
- R10: A claimed cycle produces exactly one strobe, never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| frameN | input | 1 | Active-low cycle framing strobe |
| ladIn | input | 4 | Nibble seen on the LAD lines |
| ladOut | output | 4 | Nibble the target drives onto LAD |
| ladOe | output | 1 | Output enable for ladOut |
| regAddr | output | 16 | Register port address |
| regWdata | output | 8 | Register port write byte |
| regWr | output | 1 | One-clock write strobe |
| regRd | output | 1 | One-clock read strobe |
| regRdata | input | 8 | Register port read byte, sampled while regRd is high |

## Verification
The assertions assume the host obeys the framing rules. LAD holds 0000 with the frame strobe low only when a new cycle is meant to start, and the host does not drive frames while the target owns the bus unless it intends to abort. They also assume regRdata is valid in the clock where regRd is high. The stimulus drives every nibble on the falling edge, one nibble per clock, in legal order. It breaks that order only on purpose, with a frame strobe placed in the address phase, the host turnaround or the SYNC phase, so each abort lands at a known state. Address sweeps cross both window edges, and every cycle-type code is tried.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CYC, ST_ADDR, ST_WDATA, ST_HTAR,
    ST_SYNCW, ST_SYNCR, ST_RDATA, ST_TTAR
  } lpcState_t;

  typedef enum logic [2:0] {
    DRV_NONE, DRV_WAIT, DRV_READY, DRV_DLO, DRV_DHI, DRV_TURN
  } drvSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    addrShift;
    logic    dataLo;
    logic    dataHi;
    logic    rdCapture;
    drvSel_t drvSel;
  } dpCtrl_t;

  localparam logic [3:0] NIB_START = 4'h0;
  localparam logic [3:0] NIB_IORD  = 4'h0;
  localparam logic [3:0] NIB_IOWR  = 4'h2;
  localparam logic [3:0] NIB_WAIT  = 4'h5;
  localparam logic [3:0] NIB_READY = 4'h0;
  localparam logic [3:0] NIB_TURN  = 4'hF;

endpackage

// File: rtl/lpc_tgt_ctrl.sv
module lpc_tgt_ctrl
  import lpc_tgt_pkg::*;
#(
  parameter int WAIT_SYNCS = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic [3:0] ladIn,
  input  logic       addrHit,
  output dpCtrl_t    ctl,
  output logic       regWr,
  output logic       regRd
);
  localparam int WCW = (WAIT_SYNCS > 1) ? $clog2(WAIT_SYNCS) : 1;
  localparam logic [WCW-1:0] WAIT_LAST = WCW'(WAIT_SYNCS - 1);

  lpcState_t      state, stateNxt;
  logic [1:0]     nibCnt, cntNxt;
  logic           isWrite, wrNxt;
  logic [WCW-1:0] waitCnt, waitNxt;

  always_comb begin
    stateNxt = state;
    cntNxt   = nibCnt;
    wrNxt    = isWrite;
    waitNxt  = waitCnt;
    ctl      = '0;
    regWr    = 1'b0;
    regRd    = 1'b0;

    unique case (state)
      ST_SYNCW: ctl.drvSel = DRV_WAIT;
      ST_SYNCR: ctl.drvSel = DRV_READY;
      ST_RDATA: ctl.drvSel = nibCnt[0] ? DRV_DHI : DRV_DLO;
      ST_TTAR:  ctl.drvSel = nibCnt[0] ? DRV_NONE : DRV_TURN;
      default:  ctl.drvSel = DRV_NONE;
    endcase

    if (!frameN) begin
      stateNxt = (ladIn == NIB_START) ? ST_CYC : ST_IDLE;
      cntNxt   = 2'd0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_CYC: begin
          cntNxt = 2'd0;
          if (ladIn == NIB_IORD) begin
            wrNxt = 1'b0; stateNxt = ST_ADDR;
          end else if (ladIn == NIB_IOWR) begin
            wrNxt = 1'b1; stateNxt = ST_ADDR;
          end else begin
            stateNxt = ST_IDLE;
          end
        end
        ST_ADDR: begin
          ctl.addrShift = 1'b1;
          cntNxt = nibCnt + 2'd1;
          if (nibCnt == 2'd3) stateNxt = isWrite ? ST_WDATA : ST_HTAR;
        end
        ST_WDATA: begin
          ctl.dataLo = (nibCnt == 2'd0);
          ctl.dataHi = (nibCnt == 2'd1);
          if (nibCnt == 2'd1) begin
            cntNxt = 2'd0; stateNxt = ST_HTAR;
          end else begin
            cntNxt = nibCnt + 2'd1;
          end
        end
        ST_HTAR: begin
          if (nibCnt == 2'd0) begin
            if (!addrHit) stateNxt = ST_IDLE;
            else cntNxt = 2'd1;
          end else begin
            if (isWrite) regWr = 1'b1;
            else begin
              regRd = 1'b1;
              ctl.rdCapture = 1'b1;
            end
            cntNxt   = 2'd0;
            waitNxt  = '0;
            stateNxt = ST_SYNCW;
          end
        end
        ST_SYNCW: begin
          if (waitCnt == WAIT_LAST) stateNxt = ST_SYNCR;
          else waitNxt = waitCnt + 1'b1;
        end
        ST_SYNCR: begin
          cntNxt   = 2'd0;
          stateNxt = isWrite ? ST_TTAR : ST_RDATA;
        end
        ST_RDATA, ST_TTAR: begin
          if (nibCnt == 2'd1) begin
            cntNxt   = 2'd0;
            stateNxt = (state == ST_RDATA) ? ST_TTAR : ST_IDLE;
          end else begin
            cntNxt = nibCnt + 2'd1;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      nibCnt  <= 2'd0;
      isWrite <= 1'b0;
      waitCnt <= '0;
    end else begin
      state   <= stateNxt;
      nibCnt  <= cntNxt;
      isWrite <= wrNxt;
      waitCnt <= waitNxt;
    end
  end

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regRd));

  assert_strobe_needs_hit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWr || regRd) |-> addrHit);

  assert_abort_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> (ctl.drvSel == DRV_NONE));

  assert_cyctype_after_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CYC) |-> ($past(!frameN) && ($past(ladIn) == NIB_START)));

  assert_ready_after_wait_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SYNCR) |-> ($past(state) == ST_SYNCW));
endmodule

// File: rtl/lpc_tgt_datapath.sv
module lpc_tgt_datapath
  import lpc_tgt_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR   = 16'h0060,
  parameter int          WINDOW_SIZE = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  ladIn,
  input  dpCtrl_t     ctl,
  input  logic [7:0]  regRdata,
  output logic [15:0] regAddr,
  output logic [7:0]  regWdata,
  output logic        addrHit,
  output logic [3:0]  ladOut,
  output logic        ladOe
);
  localparam logic [16:0] WIN_LO = {1'b0, BASE_ADDR};
  localparam logic [16:0] WIN_HI = WIN_LO + 17'(WINDOW_SIZE);

  logic [15:0] addrReg;
  logic [7:0]  byteReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      byteReg <= '0;
    end else begin
      if (ctl.addrShift) addrReg <= {addrReg[11:0], ladIn};
      if (ctl.dataLo)    byteReg[3:0] <= ladIn;
      if (ctl.dataHi)    byteReg[7:4] <= ladIn;
      if (ctl.rdCapture) byteReg <= regRdata;
    end
  end

  assign addrHit  = ({1'b0, addrReg} >= WIN_LO) && ({1'b0, addrReg} < WIN_HI);
  assign regAddr  = addrReg;
  assign regWdata = byteReg;

  always_comb begin
    ladOe  = 1'b1;
    unique case (ctl.drvSel)
      DRV_WAIT:  ladOut = NIB_WAIT;
      DRV_READY: ladOut = NIB_READY;
      DRV_DLO:   ladOut = byteReg[3:0];
      DRV_DHI:   ladOut = byteReg[7:4];
      DRV_TURN:  ladOut = NIB_TURN;
      default: begin
        ladOut = NIB_TURN;
        ladOe  = 1'b0;
      end
    endcase
  end

  assert_turn_then_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.drvSel == DRV_TURN) |=> !ladOe);

  assert_data_after_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.drvSel == DRV_DLO) |-> ($past(ctl.drvSel) == DRV_READY));
endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
  import lpc_tgt_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR   = 16'h0060,
  parameter int          WINDOW_SIZE = 8,
  parameter int          WAIT_SYNCS  = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic [3:0]  ladIn,
  output logic [3:0]  ladOut,
  output logic        ladOe,
  output logic [15:0] regAddr,
  output logic [7:0]  regWdata,
  output logic        regWr,
  output logic        regRd,
  input  logic [7:0]  regRdata
);
  dpCtrl_t ctl;
  logic    addrHit;

  lpc_tgt_ctrl #(.WAIT_SYNCS(WAIT_SYNCS)) uCtrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .ladIn(ladIn),
    .addrHit(addrHit), .ctl(ctl), .regWr(regWr), .regRd(regRd)
  );

  lpc_tgt_datapath #(.BASE_ADDR(BASE_ADDR), .WINDOW_SIZE(WINDOW_SIZE)) uDp (
    .clk(clk), .rstN(rstN), .ladIn(ladIn), .ctl(ctl), .regRdata(regRdata),
    .regAddr(regAddr), .regWdata(regWdata), .addrHit(addrHit),
    .ladOut(ladOut), .ladOe(ladOe)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!ladOe && !regWr && !regRd));
endmodule

// File: tb/tb_lpc_io_target.sv
module tb_lpc_io_target;
  localparam logic [15:0] BASE = 16'h0060;
  localparam int SIZE = 8;
  localparam int WAITS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameN = 1'b1;
  logic [3:0] ladIn = 4'hF;
  logic [3:0] ladOut;
  logic ladOe;
  logic [15:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic regWr, regRd;

  int checks = 0, fails = 0, wrCount = 0, rdCount = 0;
  logic [15:0] lastWrAddr;
  logic [7:0]  lastWrData;
  logic [7:0]  regFile [16];

  always #2 clk = ~clk;

  lpc_io_target #(.BASE_ADDR(BASE), .WINDOW_SIZE(SIZE), .WAIT_SYNCS(WAITS)) dut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .ladIn(ladIn), .ladOut(ladOut),
    .ladOe(ladOe), .regAddr(regAddr), .regWdata(regWdata), .regWr(regWr),
    .regRd(regRd), .regRdata(regRdata)
  );

  assign regRdata = regFile[regAddr[3:0]];

  always @(posedge clk) begin
    if (regWr) begin
      regFile[regAddr[3:0]] <= regWdata;
      lastWrAddr <= regAddr;
      lastWrData <= regWdata;
      wrCount++;
    end
    if (regRd) rdCount++;
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drv(input logic f, input logic [3:0] n);
    @(negedge clk);
    frameN = f;
    ladIn = n;
  endtask

  function automatic bit inWin(input logic [15:0] a);
    return (a >= BASE) && (32'(a) < 32'(BASE) + SIZE);
  endfunction

  task automatic header(input bit wr, input logic [15:0] a, input logic [7:0] d);
    drv(1'b0, 4'h0);
    drv(1'b1, wr ? 4'h2 : 4'h0);
    for (int i = 3; i >= 0; i--) drv(1'b1, a[i*4 +: 4]);
    if (wr) begin
      drv(1'b1, d[3:0]);
      drv(1'b1, d[7:4]);
    end
    drv(1'b1, 4'hF);
    drv(1'b1, 4'hF);
  endtask

  // observe the target's answer; hit=0 expects silence for the same span
  task automatic response(input bit wr, input bit hit, input logic [7:0] d, input string req);
    logic [3:0] expSeq [8];
    int n = 0;
    for (int i = 0; i < WAITS; i++) expSeq[n++] = 4'h5;
    expSeq[n++] = 4'h0;
    if (!wr) begin
      expSeq[n++] = d[3:0];
      expSeq[n++] = d[7:4];
    end
    expSeq[n++] = 4'hF;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hit) chk(ladOe && ladOut == expSeq[i], req, {11'd0, ladOe, ladOut}, {12'h001, expSeq[i]});
      else chk(!ladOe, req, {15'd0, ladOe}, 16'd0);
    end
    @(negedge clk);
    chk(!ladOe, "R8 release", {15'd0, ladOe}, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int w0, r0;
    for (int i = 0; i < 16; i++) regFile[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!ladOe && !regWr && !regRd, "R1 reset", {13'd0, ladOe, regWr, regRd}, 16'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!ladOe && !regWr && !regRd, "R1 after reset", {13'd0, ladOe, regWr, regRd}, 16'd0);

    // R4 R5 R7 R8 R10: write sweep across both window edges
    for (logic [15:0] a = BASE - 8; a < BASE + SIZE + 8; a++) begin
      w0 = wrCount;
      header(1'b1, a, a[7:0] ^ 8'hA5);
      response(1'b1, inWin(a), 8'h00, inWin(a) ? "R7 write sync" : "R4 write miss");
      chk(wrCount - w0 == (inWin(a) ? 1 : 0), "R10 write strobes", 16'(wrCount - w0), inWin(a) ? 16'd1 : 16'd0);
      if (inWin(a))
        chk(lastWrAddr == a && lastWrData == (a[7:0] ^ 8'hA5), "R5 write addr/data",
            {lastWrAddr[7:0], lastWrData}, {a[7:0], a[7:0] ^ 8'hA5});
    end

    // R6: read sweep
    for (logic [15:0] a = BASE - 8; a < BASE + SIZE + 8; a++) begin
      r0 = rdCount;
      header(1'b0, a, 8'h00);
      response(1'b0, inWin(a), a[7:0] ^ 8'hA5, inWin(a) ? "R6 read data" : "R4 read miss");
      chk(rdCount - r0 == (inWin(a) ? 1 : 0), "R6 read strobes", 16'(rdCount - r0), inWin(a) ? 16'd1 : 16'd0);
    end

    // R3: every unsupported cycle type, address inside window
    for (int t = 0; t < 16; t++) begin
      if (t == 0 || t == 2) continue;
      w0 = wrCount; r0 = rdCount;
      drv(1'b0, 4'h0);
      drv(1'b1, 4'(t));
      for (int i = 3; i >= 0; i--) drv(1'b1, BASE[i*4 +: 4]);
      for (int i = 0; i < 10; i++) begin
        drv(1'b1, (i < 2) ? 4'h0 : 4'hF);
        chk(!ladOe, "R3 unsupported type", {15'd0, ladOe}, 16'd0);
      end
      chk(wrCount == w0 && rdCount == r0, "R3 no strobe", 16'(wrCount + rdCount), 16'(w0 + r0));
    end

    // R2: extended START, then START with a non-zero nibble
    drv(1'b0, 4'h0);
    header(1'b0, BASE + 1, 8'h00);
    response(1'b0, 1'b1, (BASE[7:0] + 8'd1) ^ 8'hA5, "R2 extended start");
    r0 = rdCount;
    drv(1'b0, 4'h1);
    drv(1'b1, 4'h0);
    for (int i = 3; i >= 0; i--) drv(1'b1, BASE[i*4 +: 4]);
    drv(1'b1, 4'hF);
    drv(1'b1, 4'hF);
    response(1'b0, 1'b0, 8'h00, "R2 bad start");
    chk(rdCount == r0, "R2 bad start strobe", 16'(rdCount), 16'(r0));

    // R9 R5: abort inside the address phase of a write
    w0 = wrCount;
    drv(1'b0, 4'h0); drv(1'b1, 4'h2); drv(1'b1, 4'h0); drv(1'b1, 4'h0);
    drv(1'b0, 4'hF);
    repeat (6) drv(1'b1, 4'hF);
    chk(wrCount == w0, "R5 abort in address", 16'(wrCount), 16'(w0));

    // R5: abort in the first host turnaround clock of a write
    drv(1'b0, 4'h0); drv(1'b1, 4'h2);
    for (int i = 3; i >= 0; i--) drv(1'b1, (BASE + 2) >> (i * 4));
    drv(1'b1, 4'h1); drv(1'b1, 4'h1);
    drv(1'b0, 4'hF);
    repeat (6) drv(1'b1, 4'hF);
    chk(wrCount == w0, "R5 abort in turnaround", 16'(wrCount), 16'(w0));
    header(1'b0, BASE + 2, 8'h00);
    response(1'b0, 1'b1, (BASE[7:0] + 8'd2) ^ 8'hA5, "R5 aborted write left data");

    // R9: abort while the target drives a wait SYNC
    header(1'b0, BASE, 8'h00);
    @(negedge clk);
    chk(ladOe && ladOut == 4'h5, "R9 sync before abort", {11'd0, ladOe, ladOut}, 16'h0015);
    frameN = 1'b0; ladIn = 4'hF;
    @(negedge clk);
    chk(!ladOe, "R9 release after abort", {15'd0, ladOe}, 16'd0);
    frameN = 1'b1;
    header(1'b0, BASE + 3, 8'h00);
    response(1'b0, 1'b1, (BASE[7:0] + 8'd3) ^ 8'hA5, "R9 restart after abort");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule